// File: doc/BRIEF.md
# Endpoint Control and Status Register

This block holds the configuration and live state of one endpoint of a USB device controller. It keeps the endpoint number, the endpoint type, a type-dependent kind bit, a receive status and a transmit status, the two data-toggle bits, two transaction-complete flags and an indicator that tells whether the last accepted receive transaction was a SETUP. A processor reads the whole image at once and writes it through a single strobe.

Each field responds to a write in one of three ways. Some are plain read/write. Some flip for every 1 written. Some can only be cleared by software.

The transaction engine reports the end of each transaction, with its direction, its outcome and whether it was a SETUP. It also reports a SETUP token as soon as the token is seen. From these events the block sets the complete flags, advances or forces the toggles, moves the receive status to NAK, and captures the SETUP indicator. The interrupt output is raised while either complete flag is set and the global enable is high.

Top module: `ep_csr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `csr_rdata` is 0 and `irq` is 0.
- R2: The image layout is: [3:0] endpoint number, [5:4] transmit status, [6] transmit toggle, [7] transmit complete, [8] kind, [10:9] type (00 bulk, 01 control, 10 isochronous, 11 interrupt), [11] SETUP indicator, [13:12] receive status, [14] receive toggle, [15] receive complete. A write loads the number, kind and type fields directly. The written value of bit 11 has no effect.
- R3: For both status fields and both toggle bits, a written 1 flips the corresponding bit and a written 0 leaves it unchanged. The status codes are 00 disabled, 01 stall, 10 NAK and 11 valid.
- R4: A written 0 clears a complete flag and a written 1 leaves it unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: `xact_res` codes are 0 ACK, 1 NAK, 2 STALL, 3 protocol error, 4 toggle mismatch and 5 isochronous packet end. A transaction ending in codes 1 to 4 (or the unused codes 6 and 7) changes no field.
- R6: On a non-isochronous endpoint, an IN transaction (`xact_in`=1) ending in ACK sets the transmit complete flag and flips the transmit toggle.
- R7: On a non-isochronous endpoint, a receive transaction (`xact_in`=0) ending in ACK sets the receive complete flag, flips the receive toggle and sets the receive status to NAK (10).
- R8: A `setup_pid` pulse on a control endpoint sets the transmit toggle to 1 and clears the receive toggle to 0. These forced values win over any flip in the same cycle. On any other type, the pulse has no effect.
- R9: On a control endpoint, a successful receive loads `xact_is_setup` into the SETUP indicator only while the receive complete flag is 0. While that flag is 1, the indicator holds its value. On other endpoint types the indicator never changes.
- R10: On an isochronous endpoint, only code 5 completes a transaction, and ACK has no effect. Completion sets the flag of that direction and flips that direction's toggle, and it leaves both status fields unchanged.
- R11: A successful receive marked as SETUP on an endpoint that is not a control endpoint is ignored entirely.
- R12: `irq` is high exactly when `ctr_irq_en` is high and at least one complete flag is set. It follows the register state with no added cycle.
- R13: When hardware changes a field in a cycle, a software write to that field in the same cycle is discarded. A software write to the other fields still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe for the register image |
| csr_wdata | input | 16 | Write data, same layout as the image |
| csr_rdata | output | 16 | Current register image |
| xact_end | input | 1 | One-cycle pulse: a transaction finished |
| xact_in | input | 1 | Direction of that transaction: 1 = IN (transmit), 0 = OUT/SETUP (receive) |
| xact_is_setup | input | 1 | The receive transaction that finished was a SETUP |
| xact_res | input | 3 | Outcome code of that transaction |
| setup_pid | input | 1 | One-cycle pulse: SETUP token addressed to this endpoint |
| ctr_irq_en | input | 1 | Global enable for the complete-transfer interrupt |
| irq | output | 1 | Complete-transfer interrupt |

## Verification
Every field is visible in `csr_rdata` on the cycle after the edge that updates it. A wrong toggle, status or flag therefore shows on the first read after the offending event, before any later event can hide it. A SETUP indicator that is not frozen shows up only when a second receive completes while the flag is still set. The bench therefore drives back-to-back receives with no clear in between and compares the full image after every clock. A wrong flag also shows on `irq` in the same cycle whenever the enable is high.

// File: rtl/ep_csr_pkg.sv
package ep_csr_pkg;

    parameter int EPA_W = 4;
    localparam int STAT_W = 2;
    localparam int TYPE_W = 2;
    localparam int RES_W = 3;
    localparam int REG_W = EPA_W + 2 * STAT_W + TYPE_W + 6;

    typedef enum logic [STAT_W-1:0] {
        ST_DISABLED = 2'b00,
        ST_STALL    = 2'b01,
        ST_NAK      = 2'b10,
        ST_VALID    = 2'b11
    } stat_e;

    typedef enum logic [TYPE_W-1:0] {
        EP_BULK = 2'b00,
        EP_CTRL = 2'b01,
        EP_ISO  = 2'b10,
        EP_INTR = 2'b11
    } eptype_e;

    typedef enum logic [RES_W-1:0] {
        RS_ACK     = 3'd0,
        RS_NAK     = 3'd1,
        RS_STALL   = 3'd2,
        RS_ERR     = 3'd3,
        RS_TOGMIS  = 3'd4,
        RS_ISO_END = 3'd5
    } res_e;

    // Field order, MSB first, equals the register image layout.
    typedef struct packed {
        logic             rx_done;
        logic             rx_tog;
        stat_e            rx_stat;
        logic             setup;
        eptype_e          ep_type;
        logic             kind;
        logic             tx_done;
        logic             tx_tog;
        stat_e            tx_stat;
        logic [EPA_W-1:0] addr;
    } ep_csr_t;

endpackage

// File: rtl/ep_csr_swdec.sv
module ep_csr_swdec
    import ep_csr_pkg::*;
(
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  ep_csr_t          cur,
    output ep_csr_t          sw_nxt
);

    ep_csr_t w;
    logic    setup_unused;

    assign w = ep_csr_t'(wdata);
    assign setup_unused = w.setup;

    always_comb begin
        sw_nxt = cur;
        if (we) begin
            // plain read/write fields
            sw_nxt.addr    = w.addr;
            sw_nxt.kind    = w.kind;
            sw_nxt.ep_type = w.ep_type;
            // flip-on-one fields
            sw_nxt.tx_stat = stat_e'(cur.tx_stat ^ w.tx_stat);
            sw_nxt.rx_stat = stat_e'(cur.rx_stat ^ w.rx_stat);
            sw_nxt.tx_tog  = cur.tx_tog ^ w.tx_tog;
            sw_nxt.rx_tog  = cur.rx_tog ^ w.rx_tog;
            // clear-only flags
            sw_nxt.tx_done = cur.tx_done & w.tx_done;
            sw_nxt.rx_done = cur.rx_done & w.rx_done;
        end
    end

endmodule

// File: rtl/ep_csr_hwupd.sv
module ep_csr_hwupd
    import ep_csr_pkg::*;
(
    input  ep_csr_t          cur,
    input  ep_csr_t          sw_nxt,
    input  logic             xact_end,
    input  logic             xact_in,
    input  logic             xact_is_setup,
    input  logic [RES_W-1:0] xact_res,
    input  logic             setup_pid,
    output ep_csr_t          nxt
);

    logic is_iso;
    logic is_ctrl;
    logic res_ok;
    logic rx_ok;
    logic tx_ok;

    always_comb begin
        is_iso  = (cur.ep_type == EP_ISO);
        is_ctrl = (cur.ep_type == EP_CTRL);
        res_ok  = is_iso ? (res_e'(xact_res) == RS_ISO_END)
                         : (res_e'(xact_res) == RS_ACK);
        rx_ok   = xact_end && !xact_in && res_ok && !(xact_is_setup && !is_ctrl);
        tx_ok   = xact_end &&  xact_in && res_ok;

        nxt = sw_nxt;

        if (rx_ok) begin
            nxt.rx_done = 1'b1;
            nxt.rx_tog  = ~cur.rx_tog;
            if (!is_iso) begin
                nxt.rx_stat = ST_NAK;
            end
            if (is_ctrl && !cur.rx_done) begin
                nxt.setup = xact_is_setup;
            end
        end

        if (tx_ok) begin
            nxt.tx_done = 1'b1;
            nxt.tx_tog  = ~cur.tx_tog;
        end

        if (setup_pid && is_ctrl) begin
            nxt.tx_tog = 1'b1;
            nxt.rx_tog = 1'b0;
        end
    end

endmodule

// File: rtl/ep_csr.sv
module ep_csr
    import ep_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [REG_W-1:0] csr_wdata,
    output logic [REG_W-1:0] csr_rdata,
    input  logic             xact_end,
    input  logic             xact_in,
    input  logic             xact_is_setup,
    input  logic [RES_W-1:0] xact_res,
    input  logic             setup_pid,
    input  logic             ctr_irq_en,
    output logic             irq
);

    ep_csr_t state_q;
    ep_csr_t state_d;
    ep_csr_t sw_d;
    ep_csr_t hw_d;

    ep_csr_swdec u_swdec (
        .we     (csr_we),
        .wdata  (csr_wdata),
        .cur    (state_q),
        .sw_nxt (sw_d)
    );

    ep_csr_hwupd u_hwupd (
        .cur           (state_q),
        .sw_nxt        (sw_d),
        .xact_end      (xact_end),
        .xact_in       (xact_in),
        .xact_is_setup (xact_is_setup),
        .xact_res      (xact_res),
        .setup_pid     (setup_pid),
        .nxt           (hw_d)
    );

    always_comb begin
        state_d = hw_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign csr_rdata = state_q;
    assign irq       = ctr_irq_en && (state_q.rx_done || state_q.tx_done);

    // R4: an accepted bulk receive leaves the flag set whatever software wrote
    a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && !xact_in && !xact_is_setup && xact_res == 3'd0 &&
         state_q.ep_type == EP_BULK) |=> state_q.rx_done);

    // R5: failed outcomes never raise a complete flag
    a_r5_fail_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_end && xact_res inside {3'd1, 3'd2, 3'd3, 3'd4} &&
         !state_q.rx_done && !state_q.tx_done) |=> (!state_q.rx_done && !state_q.tx_done));

    // R8: SETUP token forces the toggle pair on control endpoints
    a_r8_setup_force: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_pid && state_q.ep_type == EP_CTRL) |=> (state_q.tx_tog && !state_q.rx_tog));

    // R9: SETUP indicator frozen while receive complete is set
    a_r9_setup_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.rx_done |=> $stable(state_q.setup));

    // R10: isochronous status untouched by hardware
    a_r10_iso_stat: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ep_type == EP_ISO && !csr_we) |=> ($stable(state_q.rx_stat) && $stable(state_q.tx_stat)));

    // R12: no interrupt while globally disabled
    a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ctr_irq_en |-> !irq);

endmodule

// File: tb/sim_ep_csr.sv
`timescale 1ns/1ps
module sim_ep_csr;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we;
    logic [15:0] csr_wdata;
    logic [15:0] csr_rdata;
    logic        xact_end;
    logic        xact_in;
    logic        xact_is_setup;
    logic [2:0]  xact_res;
    logic        setup_pid;
    logic        ctr_irq_en;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;
    logic [15:0] model;

    always #10 clk = ~clk;

    ep_csr u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .xact_end(xact_end), .xact_in(xact_in),
        .xact_is_setup(xact_is_setup), .xact_res(xact_res), .setup_pid(setup_pid),
        .ctr_irq_en(ctr_irq_en), .irq(irq)
    );

    function automatic logic [15:0] next_img(input logic [15:0] c, input logic we,
            input logic [15:0] wd, input logic xe, input logic xi, input logic xs,
            input logic [2:0] xr, input logic sp);
        logic [15:0] n;
        logic iso, ctrl, ok;
        n = c;
        iso  = (c[10:9] == 2'b10);
        ctrl = (c[10:9] == 2'b01);
        if (we) begin
            n[3:0]   = wd[3:0];
            n[8]     = wd[8];
            n[10:9]  = wd[10:9];
            n[5:4]   = c[5:4] ^ wd[5:4];
            n[6]     = c[6] ^ wd[6];
            n[13:12] = c[13:12] ^ wd[13:12];
            n[14]    = c[14] ^ wd[14];
            n[7]     = c[7] & wd[7];
            n[15]    = c[15] & wd[15];
        end
        ok = xe && (iso ? (xr == 3'd5) : (xr == 3'd0));
        if (ok && !xi && !(xs && !ctrl)) begin
            n[15] = 1'b1;
            n[14] = ~c[14];
            if (!iso) n[13:12] = 2'b10;
            if (ctrl && !c[15]) n[11] = xs;
        end
        if (ok && xi) begin
            n[7] = 1'b1;
            n[6] = ~c[6];
        end
        if (sp && ctrl) begin
            n[6]  = 1'b1;
            n[14] = 1'b0;
        end
        return n;
    endfunction

    // write that changes nothing: keep rw fields, flags written 1, no flips
    function automatic logic [15:0] neutral(input logic [15:0] c);
        return (c & 16'h070F) | 16'h8080;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [15:0] wd, input logic xe,
            input logic xi, input logic xs, input logic [2:0] xr, input logic sp,
            input logic en, input string tag);
        logic [15:0] exp;
        @(negedge clk);
        csr_we = we; csr_wdata = wd; xact_end = xe; xact_in = xi;
        xact_is_setup = xs; xact_res = xr; setup_pid = sp; ctr_irq_en = en;
        exp = next_img(model, we, wd, xe, xi, xs, xr, sp);
        @(posedge clk);
        #1;
        check(csr_rdata, exp, tag);
        check({15'd0, irq}, {15'd0, en & (exp[15] | exp[7])}, "R12 irq");
        model = exp;
    endtask

    task automatic idle();
        cyc(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, "idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7531));
        rst_n = 1'b0; csr_we = 0; csr_wdata = 0; xact_end = 0; xact_in = 0;
        xact_is_setup = 0; xact_res = 0; setup_pid = 0; ctr_irq_en = 1;
        model = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(csr_rdata, 16'h0, "R1 reset image");
        check({15'd0, irq}, 16'h0, "R1 reset irq");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(csr_rdata, 16'h0, "R1 first cycle");

        // R2: control endpoint, number A, kind 1, setup bit written 1
        cyc(1, 16'h0B0A, 0, 0, 0, 0, 0, 1, "R2 rw load");
        check(csr_rdata, 16'h030A, "R2 literal");
        // R3: flip rx status to 11 and tx toggle
        cyc(1, neutral(model) | 16'h3040, 0, 0, 0, 0, 0, 1, "R3 flip");
        check(csr_rdata, 16'h334A, "R3 literal");
        cyc(1, neutral(model) | 16'h1000, 0, 0, 0, 0, 0, 1, "R3 flip again");
        check({14'd0, csr_rdata[13:12]}, 16'd2, "R3 stat 10");
        // R8: setup token on control
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8 setup pid");
        check({14'd0, csr_rdata[14], csr_rdata[6]}, 16'd1, "R8 toggles");
        // R7 / R9: accepted SETUP then accepted OUT while flag set
        cyc(0, 0, 1, 0, 1, 3'd0, 0, 1, "R7 setup accepted");
        check({15'd0, csr_rdata[11]}, 16'd1, "R9 setup captured");
        cyc(0, 0, 1, 0, 0, 3'd0, 0, 1, "R9 frozen");
        check({15'd0, csr_rdata[11]}, 16'd1, "R9 still set");
        // R12: masked
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R12 masked");
        // R4: clear rx flag, then write 1 has no effect, then set wins over clear
        cyc(1, neutral(model) & 16'h7FFF, 0, 0, 0, 0, 0, 1, "R4 clear");
        check({15'd0, csr_rdata[15]}, 16'd0, "R4 cleared");
        cyc(1, neutral(model), 0, 0, 0, 0, 0, 1, "R4 write one");
        cyc(1, neutral(model) & 16'h7FFF, 1, 0, 0, 3'd0, 0, 1, "R4 set wins");
        check({15'd0, csr_rdata[15]}, 16'd1, "R4 set wins bit");
        cyc(1, neutral(model) & 16'h7F7F, 0, 0, 0, 0, 0, 1, "R4 clear both");
        // R5: failed outcomes
        for (int r = 1; r < 5; r++) cyc(0, 0, 1, r[0], 0, 3'(r), 0, 1, "R5 failure");
        // R6: IN ack
        cyc(0, 0, 1, 1, 0, 3'd0, 0, 1, "R6 in ack");
        // R13: software flips rx toggle while hardware flips it
        cyc(1, neutral(model) | 16'h4000, 1, 0, 0, 3'd0, 0, 1, "R13 hw over sw");
        // R10: isochronous
        cyc(1, (neutral(model) & 16'hF9FF) | 16'h0400 | 16'h1000, 0, 0, 0, 0, 0, 1, "R10 to iso");
        cyc(0, 0, 1, 0, 0, 3'd0, 0, 1, "R10 ack ignored");
        cyc(1, neutral(model) & 16'h7F7F, 0, 0, 0, 0, 0, 1, "R10 clear");
        cyc(0, 0, 1, 0, 0, 3'd5, 0, 1, "R10 iso rx end");
        check({14'd0, csr_rdata[13:12]}, 16'd3, "R10 stat kept");
        cyc(0, 0, 1, 1, 0, 3'd5, 0, 1, "R10 iso tx end");
        cyc(0, 0, 0, 0, 0, 0, 1, 1, "R8 pid ignored on iso");
        // R11: SETUP on bulk
        cyc(1, (neutral(model) & 16'h797F) , 0, 0, 0, 0, 0, 1, "R11 to bulk");
        cyc(0, 0, 1, 0, 1, 3'd0, 0, 1, "R11 setup on bulk");
        check({15'd0, csr_rdata[15]}, 16'd0, "R11 flag clear");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic [15:0] d;
            w = ($urandom % 10) < 3;
            d = 16'($urandom);
            if (($urandom % 4) != 0) d = d | 16'h8080;
            cyc(w, d, ($urandom % 10) < 4, 1'($urandom), 1'($urandom),
                3'($urandom % 8 < 5 ? ($urandom % 2) * 5 : $urandom % 8),
                ($urandom % 10) == 0, 1'($urandom), "R13 random");
        end
        idle();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule